// File: doc/BRIEF.md
# Response Compactor with Count and Division Signatures

The block compacts the response of a circuit under self-test into three results that are built side by side from the same stream: the number of ones, the number of value changes between consecutive bits, and a 4-bit remainder of polynomial division by 1+x+x^4. Because all three come from one pass over the data, a test engineer can see at once which of the three methods would have caught a given faulty response and which would have let it through.

A run begins with a `start` pulse that clears every result. Response bits then arrive on `resp_in` qualified by `in_valid`, and the bit flagged with `in_last` closes the run. In serial mode only lane 0 is used. In multi-input mode the four lanes are folded into the same 4-bit register, which then works as a multiple-input signature register. On the cycle after the closing bit, `done` pulses and `mismatch` reports whether any of the selected results differs from its expected value.

Top module: `resp_compactor`

## Requirements
- R1: Reset, or a `start` pulse, clears `ones_cnt`, `trans_cnt`, `signature`, `done` and `mismatch` to zero on the next clock edge.
- R2: `ones_cnt` counts the 1s seen on lane 0 over valid cycles, wrapping modulo 16 (stream 01101111 gives 6, stream 00110001 gives 3, seventeen 1s give 1).
- R3: `trans_cnt` counts valid lane-0 bits that differ from the previous valid bit; the first bit after `start` is never counted, and the count wraps modulo 16 (both 01101111 and 00110001 give 3).
- R4: In serial mode (`multi_mode`=0), the signature is the remainder of the lane-0 stream divided by 1+x+x^4, shifted in highest-order coefficient first; `signature[i]` is the x^i coefficient. Stream 10011011, leftmost bit being x^0, gives x^0..x^3 = 1,0,1,1 (`signature`=4'b1101). Lanes 1 to 3 have no effect in this mode.
- R5: In multi-input mode, the lanes M0..M3 (`resp_in[0]`..`resp_in[3]`) are combined as M0+x·M1+x^2·M2+x^3·M3 before division; streams 00010, 00010, 11100, 10000 give x^0..x^3 = 0,0,1,1 (`signature`=4'b1100).
- R6: Cycles with `in_valid` low leave all three results unchanged, whatever `resp_in`, `multi_mode` and `in_last` carry.
- R7: `done` is high for exactly the one cycle following a valid bit with `in_last` set, and is low otherwise.
- R8: When `done` rises, `mismatch` is the OR of the comparisons selected by `cmp_sel` (bit 0: ones count against `gold_ones`, bit 1: transition count against `gold_trans`, bit 2: signature against `gold_sig`), sampled with the closing bit; it then holds until the next closing bit or `start`.
- R9: The stream 11111111 yields the same signature as 10011011, so with only the signature comparison selected and the golden value of 10011011, `mismatch` stays 0 (an undetected alias).
- R10: A cycle with `start` and `in_valid` both high clears the results and discards that cycle's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears all results for a new run |
| in_valid | input | 1 | Qualifies `resp_in` for this cycle |
| in_last | input | 1 | Marks the closing bit of a run |
| multi_mode | input | 1 | 1: fold all lanes, 0: lane 0 only |
| resp_in | input | 4 | Response lanes, lane 0 is the serial stream |
| gold_ones | input | 4 | Expected ones count |
| gold_trans | input | 4 | Expected transition count |
| gold_sig | input | 4 | Expected signature |
| cmp_sel | input | 3 | Selects which comparisons feed `mismatch` |
| ones_cnt | output | 4 | Ones count |
| trans_cnt | output | 4 | Transition count |
| signature | output | 4 | Division remainder, bit i is the x^i coefficient |
| done | output | 1 | One-cycle pulse after the closing bit |
| mismatch | output | 1 | Selected comparison result, held between runs |

## Verification
The hardest situation to reach is an alias, where a different stream leaves the same remainder, because only error patterns that are multiples of 1+x+x^4 produce one. The bench reaches it both by the known 11111111 case and by sweeping all 256 eight-bit serial streams, each compared against remainders computed by long division in the bench, so every alias among them is exercised. Multi-input mode is driven from pseudo-random lane sets whose expected remainder comes from first forming the combined polynomial, a route independent of the per-cycle folding.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;
  localparam int CMP_N     = 3;
  localparam int CMP_ONES  = 0;
  localparam int CMP_TRANS = 1;
  localparam int CMP_SIG   = 2;
  typedef logic [CMP_N-1:0] cmp_sel_t;
endpackage

// File: rtl/rc_counters.sv
`timescale 1ns/1ps
module rc_counters #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic             bit_in,
  output logic [CNT_W-1:0] ones_q,
  output logic [CNT_W-1:0] ones_d,
  output logic [CNT_W-1:0] trans_q,
  output logic [CNT_W-1:0] trans_d
);
  logic prev_q;
  logic seen_q;

  always_comb begin
    ones_d  = ones_q;
    trans_d = trans_q;
    if (start) begin
      ones_d  = '0;
      trans_d = '0;
    end else if (step) begin
      ones_d = ones_q + CNT_W'(bit_in);
      if (seen_q && (bit_in != prev_q))
        trans_d = trans_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q  <= '0;
      trans_q <= '0;
      prev_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      ones_q  <= ones_d;
      trans_q <= trans_d;
      if (start) begin
        seen_q <= 1'b0;
        prev_q <= 1'b0;
      end else if (step) begin
        seen_q <= 1'b1;
        prev_q <= bit_in;
      end
    end
  end

  // R1: start clears both counters
  a_r1_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    start |=> (ones_q == '0 && trans_q == '0));
  // R2: each valid bit adds its value to the ones count
  a_r2_ones_step: assert property (@(posedge clk) disable iff (rst)
    (step && !start) |=> ones_q == $past(ones_q) + CNT_W'($past(bit_in)));
  // R3: the first bit after a clear never counts as a transition
  a_r3_first_bit: assert property (@(posedge clk) disable iff (rst)
    start ##1 (step && !start) |=> trans_q == '0);
  // R6: idle cycles keep both counts
  a_r6_cnt_idle: assert property (@(posedge clk) disable iff (rst)
    (!step && !start) |=> ($stable(ones_q) && $stable(trans_q)));
endmodule

// File: rtl/rc_sig.sv
`timescale 1ns/1ps
module rc_sig #(
  parameter int               SIG_W = 4,
  parameter logic [SIG_W-1:0] POLY  = SIG_W'(3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic             multi,
  input  logic [SIG_W-1:0] lanes,
  output logic [SIG_W-1:0] sig_q,
  output logic [SIG_W-1:0] sig_d
);
  localparam int TOP = SIG_W - 1;

  logic [SIG_W-1:0] feed;
  logic [SIG_W-1:0] shifted;

  assign feed[0] = lanes[0];

  for (genvar i = 0; i < SIG_W; i++) begin : g_stage
    if (i == 0) begin : g_low
      assign shifted[i] = POLY[i] & sig_q[TOP];
    end else begin : g_up
      assign shifted[i] = sig_q[i-1] ^ (POLY[i] & sig_q[TOP]);
      assign feed[i]    = multi & lanes[i];
    end
  end

  always_comb begin
    if (start)     sig_d = '0;
    else if (step) sig_d = shifted ^ feed;
    else           sig_d = sig_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sig_q <= '0;
    else     sig_q <= sig_d;
  end

  // R1: start clears the signature
  a_r1_sig_clear: assert property (@(posedge clk) disable iff (rst)
    start |=> sig_q == '0);
  // R6: idle cycles keep the signature
  a_r6_sig_idle: assert property (@(posedge clk) disable iff (rst)
    (!step && !start) |=> $stable(sig_q));
  // R4: a zero bit into an empty register leaves it empty in serial mode
  a_r4_zero_in: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !multi && !lanes[0] && sig_q == '0) |=> sig_q == '0);
endmodule

// File: rtl/rc_judge.sv
`timescale 1ns/1ps
module rc_judge
  import rc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SIG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             fin,
  input  logic [CNT_W-1:0] ones_d,
  input  logic [CNT_W-1:0] trans_d,
  input  logic [SIG_W-1:0] sig_d,
  input  logic [CNT_W-1:0] gold_ones,
  input  logic [CNT_W-1:0] gold_trans,
  input  logic [SIG_W-1:0] gold_sig,
  input  cmp_sel_t         sel,
  output logic             done,
  output logic             mismatch
);
  logic [CMP_N-1:0] diff;
  logic             miss_d;

  assign diff[CMP_ONES]  = (ones_d  != gold_ones);
  assign diff[CMP_TRANS] = (trans_d != gold_trans);
  assign diff[CMP_SIG]   = (sig_d   != gold_sig);
  assign miss_d          = |(diff & sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      done <= fin;
      if (start)    mismatch <= 1'b0;
      else if (fin) mismatch <= miss_d;
    end
  end

  // R7: done only follows a closing bit
  a_r7_done_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(fin));
  // R8: with nothing selected the flag stays clear
  a_r8_sel_none: assert property (@(posedge clk) disable iff (rst)
    (done && $past(sel) == '0) |-> !mismatch);
  // R8: flag holds between runs
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(start)) |-> $stable(mismatch));
endmodule

// File: rtl/resp_compactor.sv
`timescale 1ns/1ps
module resp_compactor
  import rc_pkg::*;
#(
  parameter int               CNT_W = 4,
  parameter int               SIG_W = 4,
  parameter logic [SIG_W-1:0] POLY  = SIG_W'(3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             multi_mode,
  input  logic [SIG_W-1:0] resp_in,
  input  logic [CNT_W-1:0] gold_ones,
  input  logic [CNT_W-1:0] gold_trans,
  input  logic [SIG_W-1:0] gold_sig,
  input  logic [CMP_N-1:0] cmp_sel,
  output logic [CNT_W-1:0] ones_cnt,
  output logic [CNT_W-1:0] trans_cnt,
  output logic [SIG_W-1:0] signature,
  output logic             done,
  output logic             mismatch
);
  logic             step;
  logic             fin;
  logic [CNT_W-1:0] ones_d;
  logic [CNT_W-1:0] trans_d;
  logic [SIG_W-1:0] sig_d;

  assign step = in_valid & ~start;
  assign fin  = step & in_last;

  rc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .step(step), .bit_in(resp_in[0]),
    .ones_q(ones_cnt), .ones_d(ones_d), .trans_q(trans_cnt), .trans_d(trans_d)
  );

  rc_sig #(.SIG_W(SIG_W), .POLY(POLY)) u_sig (
    .clk(clk), .rst(rst), .start(start), .step(step), .multi(multi_mode),
    .lanes(resp_in), .sig_q(signature), .sig_d(sig_d)
  );

  rc_judge #(.CNT_W(CNT_W), .SIG_W(SIG_W)) u_judge (
    .clk(clk), .rst(rst), .start(start), .fin(fin),
    .ones_d(ones_d), .trans_d(trans_d), .sig_d(sig_d),
    .gold_ones(gold_ones), .gold_trans(gold_trans), .gold_sig(gold_sig),
    .sel(cmp_sel), .done(done), .mismatch(mismatch)
  );

  // R10: a start cycle discards its bit, results are zero afterwards
  a_r10_start_wins: assert property (@(posedge clk) disable iff (rst)
    (start && in_valid) |=> (ones_cnt == '0 && signature == '0 && !done));
endmodule

// File: tb/resp_compactor_tb.sv
`timescale 1ns/1ps
module resp_compactor_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, in_valid = 1'b0, in_last = 1'b0, multi_mode = 1'b0;
  logic [3:0] resp_in = '0, gold_ones = '0, gold_trans = '0, gold_sig = '0;
  logic [2:0] cmp_sel = '0;
  logic [3:0] ones_cnt, trans_cnt, signature;
  logic       done, mismatch;

  int n_chk = 0, n_bad = 0;
  logic [3:0] r_ones, r_trans, r_sig;
  logic       r_mis;

  always #10 clk = ~clk;

  resp_compactor u_dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_last(in_last),
    .multi_mode(multi_mode), .resp_in(resp_in), .gold_ones(gold_ones),
    .gold_trans(gold_trans), .gold_sig(gold_sig), .cmp_sel(cmp_sel),
    .ones_cnt(ones_cnt), .trans_cnt(trans_cnt), .signature(signature),
    .done(done), .mismatch(mismatch)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // remainder of a polynomial (bit i = coefficient of x^i) by 1+x+x^4
  function automatic logic [3:0] poly_rem(input logic [63:0] p, input int len);
    int r = 0;
    for (int i = len - 1; i >= 0; i--) begin
      r = (r << 1) | int'(p[i]);
      if ((r & 16) != 0) r = r ^ 19;
    end
    return 4'(r);
  endfunction

  function automatic int ones_of(input logic [31:0] s, input int len);
    int c = 0;
    for (int i = 0; i < len; i++) c += int'(s[i]);
    return c % 16;
  endfunction

  function automatic int trans_of(input logic [31:0] s, input int len);
    int c = 0;
    for (int i = 0; i + 1 < len; i++) if (s[i] != s[i+1]) c++;
    return c % 16;
  endfunction

  task automatic run(input logic [31:0] m0, m1, m2, m3, input int len, input logic mm,
                     input int gap, input logic collide,
                     input logic [3:0] go, gt, gs, input logic [2:0] sel);
    @(negedge clk);
    start = 1'b1; in_valid = collide; in_last = 1'b0; resp_in = 4'hF;
    gold_ones = go; gold_trans = gt; gold_sig = gs; cmp_sel = sel;
    @(negedge clk);
    start = 1'b0;
    for (int i = len - 1; i >= 0; i--) begin
      if (gap > 0 && (i % 3) == 1) begin
        logic [3:0] so = ones_cnt, st = trans_cnt, ss = signature;
        for (int g = 0; g < gap; g++) begin
          in_valid = 1'b0; in_last = 1'b1; multi_mode = ~mm; resp_in = 4'(i + g + 5);
          @(negedge clk);
          check("R6 idle ones", ones_cnt, so);
          check("R6 idle trans", trans_cnt, st);
          check("R6 idle sig", signature, ss);
          check("R6 idle done", done, 0);
        end
      end
      in_valid = 1'b1; in_last = (i == 0); multi_mode = mm;
      resp_in = {m3[i], m2[i], m1[i], m0[i]};
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    check("R7 done after last", done, 1);
    r_ones = ones_cnt; r_trans = trans_cnt; r_sig = signature; r_mis = mismatch;
    @(negedge clk);
    check("R7 done one cycle", done, 0);
    check("R8 mismatch held", mismatch, r_mis);
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset ones", ones_cnt, 0);
    check("R1 reset trans", trans_cnt, 0);
    check("R1 reset sig", signature, 0);
    check("R1 reset done", done, 0);
    check("R1 reset mismatch", mismatch, 0);

    // known streams, bit i = x^i coefficient
    run(32'hD9, 32'h26, 32'h55, 32'hAA, 8, 1'b0, 0, 1'b0, 4'd5, 4'd4, 4'b1101, 3'b111);
    check("R4 sig 10011011", r_sig, 4'b1101);
    check("R8 all match", r_mis, 0);
    run(32'hF6, 0, 0, 0, 8, 1'b0, 0, 1'b0, 0, 0, 0, 3'b000);
    check("R2 ones 01101111", r_ones, 6);
    check("R3 trans 01101111", r_trans, 3);
    run(32'h8C, 0, 0, 0, 8, 1'b0, 0, 1'b0, 0, 0, 0, 3'b000);
    check("R2 ones 00110001", r_ones, 3);
    check("R3 trans 00110001", r_trans, 3);
    // alias
    run(32'hFF, 0, 0, 0, 8, 1'b0, 0, 1'b0, 4'd5, 4'd4, 4'b1101, 3'b100);
    check("R9 alias sig", r_sig, 4'b1101);
    check("R9 alias undetected", r_mis, 0);
    run(32'hFF, 0, 0, 0, 8, 1'b0, 0, 1'b0, 4'd5, 4'd4, 4'b1101, 3'b001);
    check("R9 ones count detects", r_mis, 1);

    // exhaustive serial sweep, other lanes carry junk
    for (int v = 0; v < 256; v++) begin
      logic [3:0] eo, et, es;
      eo = 4'(ones_of(32'(v), 8)); et = 4'(trans_of(32'(v), 8)); es = poly_rem(64'(v), 8);
      run(32'(v), 32'(~v), 32'(v * 7), 32'(v ^ 8'h3C), 8, 1'b0, 0, 1'b0, eo, et, es, 3'b111);
      check("R2 sweep ones", r_ones, eo);
      check("R3 sweep trans", r_trans, et);
      check("R4 sweep sig", r_sig, es);
      check("R8 sweep match", r_mis, 0);
    end

    // multi-input example: M0=x^3, M1=x^3, M2=1+x+x^2, M3=1
    run(32'h08, 32'h08, 32'h07, 32'h01, 5, 1'b1, 0, 1'b0, 0, 0, 0, 3'b000);
    check("R5 misr example", r_sig, 4'b1100);

    seed = 32'h1ACE5EED;
    for (int k = 0; k < 40; k++) begin
      logic [4:0] a0, a1, a2, a3;
      logic [63:0] comb;
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      {a3, a2, a1, a0} = seed[19:0];
      comb = 64'(a0) ^ (64'(a1) << 1) ^ (64'(a2) << 2) ^ (64'(a3) << 3);
      run(32'(a0), 32'(a1), 32'(a2), 32'(a3), 5, 1'b1, 0, 1'b0, 0, 0, 0, 3'b000);
      check("R5 misr sweep", r_sig, poly_rem(comb, 8));
      check("R2 misr lane0 ones", r_ones, ones_of(32'(a0), 5));
    end

    // selection versus wrong fields
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 8; w++) begin
        logic [3:0] go, gt, gs;
        go = 4'd5 ^ 4'(w & 1); gt = 4'd4 ^ 4'((w >> 1) & 1); gs = 4'b1101 ^ 4'((w >> 2) & 1);
        run(32'hD9, 0, 0, 0, 8, 1'b0, 0, 1'b0, go, gt, gs, 3'(s));
        check("R8 select", r_mis, int'((s & w) != 0));
      end

    // wrap-around
    run(32'h1FFFF, 0, 0, 0, 17, 1'b0, 0, 1'b0, 0, 0, 0, 3'b000);
    check("R2 ones wrap", r_ones, 1);
    check("R3 no trans all ones", r_trans, 0);
    run(32'h2AAAA, 0, 0, 0, 18, 1'b0, 0, 1'b0, 0, 0, 0, 3'b000);
    check("R3 trans wrap", r_trans, 1);
    check("R4 long sig", r_sig, poly_rem(64'h2AAAA, 18));

    // idle gaps inside a stream
    run(32'hD9, 32'hFF, 32'hFF, 32'hFF, 8, 1'b0, 3, 1'b0, 0, 0, 0, 3'b000);
    check("R6 gap ones", r_ones, 5);
    check("R6 gap trans", r_trans, 4);
    check("R6 gap sig", r_sig, 4'b1101);

    // start collides with a valid bit
    run(32'h8C, 0, 0, 0, 8, 1'b0, 0, 1'b1, 0, 0, 0, 3'b000);
    check("R10 collide ones", r_ones, 3);
    check("R10 collide trans", r_trans, 3);
    check("R10 collide sig", r_sig, poly_rem(64'h8C, 8));

    // start clears results and flag
    run(32'hD9, 0, 0, 0, 8, 1'b0, 0, 1'b0, 0, 0, 0, 3'b111);
    check("R8 flagged before clear", r_mis, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R1 start ones", ones_cnt, 0);
    check("R1 start trans", trans_cnt, 0);
    check("R1 start sig", signature, 0);
    check("R1 start mismatch", mismatch, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule